// File: doc/BRIEF.md
# PHY Control-Register Bus Master

This block carries single 16-bit register reads and writes from a client to a serial-link PHY. The two sides meet over a narrow control-register bus: a 20-bit control word that the block drives, and a 17-bit status word that the PHY returns. Every step of a transaction is a complete four-phase handshake. The block raises one strobe and waits for the PHY's acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low again.

A client pulses `req` for one cycle with `we`, `addr` and `wdata`. The block first latches the address into the PHY. For a read, it then pulses the read strobe and captures the data that the PHY presents while it acknowledges. For a write, it first loads the data word and then pulses the write strobe. Each wait on the acknowledge may last only a bounded number of polls. If one runs out, the block abandons the transaction, clears the control word and reports an error. The acknowledge passes through a two-flop synchronizer, because the PHY's bus may run on its own clock.

The state machine has these states. IDLE waits for `req`. ADR_HI drives the address with the capture-address strobe and waits for ack high. ADR_LO holds the address without a strobe and waits for ack low. RD_HI drives the read strobe and waits for ack high, sampling the data when it arrives. RD_LO clears the word and waits for ack low. DAT_HI drives the data with the capture-data strobe and waits for ack high. DAT_LO holds the data and waits for ack low. WR_HI drives the write strobe and waits for ack high. WR_LO holds the data and waits for ack low. DONE clears the word and reports success. ERR_CLR clears the word. ERR_RPT then reports the failure.

The transitions are as follows. IDLE goes to ADR_HI on `req`. ADR_LO goes to RD_HI or DAT_HI, depending on `we`. RD_LO goes to DONE. DAT_LO goes to WR_HI, and WR_LO goes to DONE. Any waiting state goes to ERR_CLR when its poll budget expires. ERR_CLR goes to ERR_RPT. DONE and ERR_RPT return to IDLE.

Top module: `phycr_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `phy_ctrl` is 0 and `done` and `err` are 0.
- R2: The address phase drives `addr` on `phy_ctrl[15:0]` with only bit 16 set among bits 19:16. Once the acknowledge (`phy_stat[16]`) is seen high, bit 16 drops while bits 15:0 keep the address, and the block waits for the acknowledge to go low.
- R3: A read (`we`=0) follows the address phase with `phy_ctrl` equal to 20'h80000 (bit 19 alone). It returns on `rdata` the value of `phy_stat[15:0]` that the PHY presents while acknowledging, with `done`=1 and `err`=0.
- R4: A write (`we`=1) follows the address phase with `wdata` on bits 15:0 and bit 17 set, as one full handshake. This is followed by bit 18 alone (20'h40000) as a second full handshake, so the addressed PHY register takes `wdata`.
- R5: Each wait for an acknowledge level lasts at most POLL_MAX cycles. If the acknowledge never rises in the address phase, `done` and `err` appear exactly POLL_MAX+1 clock edges after the edge that accepted `req`.
- R6: On a timeout, `phy_ctrl` is 0 in the cycle before the one in which `done` and `err` are both 1.
- R7: `done` is a single-cycle pulse, and at most one of `phy_ctrl` bits 19:16 is set at any time.
- R8: `req` has no effect while a transaction is in progress. The running transaction keeps its address and data, and no second transaction starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request to start a transaction when idle |
| we | input | 1 | 1 = write, 0 = read; sampled with `req` |
| addr | input | 16 | PHY register address; sampled with `req` |
| wdata | input | 16 | Write data; sampled with `req` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: the transaction timed out |
| rdata | output | 16 | Data from the last successful read |
| phy_ctrl | output | 20 | Control word: [15:0] address/data, 16 capture-address, 17 capture-data, 18 write strobe, 19 read strobe |
| phy_stat | input | 17 | Status word: [15:0] read data, 16 acknowledge |

## Verification
The assertions assume the PHY keeps `phy_stat[15:0]` steady from the moment it raises the acknowledge until the strobe drops. That is why the data lines are sampled without synchronization. They also assume the client treats `req` outside the idle state as noise, not as queued work. The bench PHY model produces its read data on the same edge on which it raises the acknowledge, and holds that data until the next read. Its acknowledge delay is drawn from 0 to 4 cycles, which is well inside the poll budget. Only the directed stuck-low and stuck-high cases drive the acknowledge outside that envelope.

// File: rtl/phycr_pkg.sv
package phycr_pkg;
    localparam int DW       = 16;
    localparam int CW       = 20;
    localparam int SW       = 17;
    localparam int B_CAPADR = 16;
    localparam int B_CAPDAT = 17;
    localparam int B_WRSTB  = 18;
    localparam int B_RDSTB  = 19;
    localparam int B_ACK    = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_RD_HI,
        ST_RD_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_WR_HI,
        ST_WR_LO,
        ST_DONE,
        ST_ERR_CLR,
        ST_ERR_RPT
    } fsm_t;
endpackage

// File: rtl/phycr_sync.sv
module phycr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else             chain[i] <= chain[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/phycr_poll.sv
module phycr_poll #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CNTW = $clog2(LIMIT + 1);
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (clr)                     cnt <= '0;
        else if (cnt != CNTW'(LIMIT - 1)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CNTW'(LIMIT - 1));
endmodule

// File: rtl/phycr_master.sv
module phycr_master #(
    parameter int POLL_MAX    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic [19:0] phy_ctrl,
    input  logic [16:0] phy_stat
);
    import phycr_pkg::*;

    fsm_t          state_q, state_d;
    logic          ack_s;
    logic          expired;
    logic          we_q;
    logic [DW-1:0] addr_q, wdata_q, rdata_q;

    phycr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (phy_stat[B_ACK]),
        .q     (ack_s)
    );

    phycr_poll #(.LIMIT(POLL_MAX)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != state_d),
        .expired (expired)
    );

    // state register and request/data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == ST_RD_HI && ack_s)
                rdata_q <= phy_stat[DW-1:0];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req) state_d = ST_ADR_HI;
            ST_ADR_HI:  if (ack_s) state_d = ST_ADR_LO;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_ADR_LO:  if (!ack_s) state_d = we_q ? ST_DAT_HI : ST_RD_HI;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_RD_HI:   if (ack_s) state_d = ST_RD_LO;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_RD_LO:   if (!ack_s) state_d = ST_DONE;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_DAT_HI:  if (ack_s) state_d = ST_DAT_LO;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_DAT_LO:  if (!ack_s) state_d = ST_WR_HI;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_WR_HI:   if (ack_s) state_d = ST_WR_LO;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_WR_LO:   if (!ack_s) state_d = ST_DONE;
                        else if (expired) state_d = ST_ERR_CLR;
            ST_DONE:    state_d = ST_IDLE;
            ST_ERR_CLR: state_d = ST_ERR_RPT;
            ST_ERR_RPT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phy_ctrl = '0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            ST_ADR_HI: begin
                phy_ctrl[DW-1:0]     = addr_q;
                phy_ctrl[B_CAPADR]   = 1'b1;
            end
            ST_ADR_LO:  phy_ctrl[DW-1:0] = addr_q;
            ST_RD_HI:   phy_ctrl[B_RDSTB] = 1'b1;
            ST_DAT_HI: begin
                phy_ctrl[DW-1:0]     = wdata_q;
                phy_ctrl[B_CAPDAT]   = 1'b1;
            end
            ST_DAT_LO:  phy_ctrl[DW-1:0] = wdata_q;
            ST_WR_HI:   phy_ctrl[B_WRSTB] = 1'b1;
            ST_WR_LO:   phy_ctrl[DW-1:0] = wdata_q;
            ST_DONE:    done = 1'b1;
            ST_ERR_RPT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/phycr_master_chk.sv
module phycr_master_chk #(
    parameter int POLL_MAX = 100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        err,
    input logic [19:0] phy_ctrl
);
    localparam int CNTW = $clog2(POLL_MAX + 1) + 1;
    logic [3:0]      stb_prev;
    logic [CNTW-1:0] hold_cnt;

    // length of an unchanged non-zero strobe pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev <= '0;
            hold_cnt <= '0;
        end else begin
            stb_prev <= phy_ctrl[19:16];
            if (phy_ctrl[19:16] != 4'b0 && phy_ctrl[19:16] == stb_prev)
                hold_cnt <= hold_cnt + 1'b1;
            else
                hold_cnt <= '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (phy_ctrl == 20'h0 && !done && !err));

    assert_capadr_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ctrl[16] |-> phy_ctrl[19:17] == 3'b0);

    assert_capadr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_ctrl[16]) |-> (phy_ctrl[19:17] == 3'b0 &&
            (phy_ctrl[15:0] == $past(phy_ctrl[15:0]) || phy_ctrl[15:0] == 16'h0)));

    assert_rdstb_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ctrl[19] |-> phy_ctrl[18:0] == 19'h0);

    assert_wrstb_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ctrl[18] |-> phy_ctrl[17:0] == 18'h0);

    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= CNTW'(POLL_MAX - 1));

    assert_clear_before_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($past(phy_ctrl) == 20'h0 && !$past(done)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phy_ctrl[19:16]) <= 1);
endmodule

bind phycr_master phycr_master_chk #(.POLL_MAX(POLL_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err      (err),
    .phy_ctrl (phy_ctrl)
);

// File: tb/sim_phycr_master.sv
module sim_phycr_master;
    localparam int POLL = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        done, err;
    logic [15:0] rdata;
    logic [19:0] ctrl;
    logic [16:0] stat;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    phycr_master #(.POLL_MAX(POLL), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .done(done), .err(err), .rdata(rdata),
        .phy_ctrl(ctrl), .phy_stat(stat)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // PHY model: mode 0 normal, 1 ack stuck low, 2 ack stuck high
    int          mode = 0;
    int          dly = 0;
    int          dcnt;
    logic        ack_m;
    logic [15:0] rd_m, adr_m, dat_m;
    logic [15:0] mem_m [16];
    logic [15:0] shadow [16];

    assign stat = {ack_m, rd_m};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_m <= 1'b0; dcnt <= 0; rd_m <= '0; adr_m <= '0; dat_m <= '0;
            for (int i = 0; i < 16; i++) mem_m[i] <= '0;
        end else if (mode == 1) ack_m <= 1'b0;
        else if (mode == 2) ack_m <= 1'b1;
        else if ((|ctrl[19:16]) != ack_m) begin
            if (dcnt >= dly) begin
                ack_m <= |ctrl[19:16];
                dcnt  <= 0;
                if (ctrl[16]) adr_m <= ctrl[15:0];
                if (ctrl[17]) dat_m <= ctrl[15:0];
                if (ctrl[18]) mem_m[adr_m[3:0]] <= dat_m;
                if (ctrl[19]) rd_m <= mem_m[adr_m[3:0]];
            end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
    end

    // control-word monitor on strobe rising edges
    logic [15:0] exp_addr = '0, exp_wdata = '0;
    logic [19:0] ctrl_prev = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ctrl[16] && !ctrl_prev[16])
                chk(ctrl[15:0] == exp_addr && ctrl[19:17] == 3'b0, "R2 address word", ctrl, {4'b0001, exp_addr});
            if (!ctrl[16] && ctrl_prev[16] && ctrl != 20'h0)
                chk(ctrl == {4'b0, exp_addr}, "R2 address held", ctrl, {4'b0, exp_addr});
            if (ctrl[19] && !ctrl_prev[19])
                chk(ctrl == 20'h80000, "R3 read strobe word", ctrl, 20'h80000);
            if (ctrl[17] && !ctrl_prev[17])
                chk(ctrl == {4'b0010, exp_wdata}, "R4 data word", ctrl, {4'b0010, exp_wdata});
            if (ctrl[18] && !ctrl_prev[18])
                chk(ctrl == 20'h40000, "R4 write strobe word", ctrl, 20'h40000);
            if ((ctrl[19:16] & (ctrl[19:16] - 4'd1)) != 4'd0)
                chk(1'b0, "R7 one strobe", ctrl[19:16], 4'd1);
        end
        ctrl_prev <= ctrl;
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic xfer(input bit w, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output bit e, output int lat,
                        output logic [19:0] ctrl_last, output bit pulse_ok);
        exp_addr = a; exp_wdata = d;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        ctrl_last = ctrl;
        while (!done && lat < 2000) begin
            ctrl_last = ctrl;
            @(posedge clk); @(negedge clk);
            lat++;
        end
        rd = rdata; e = err;
        @(posedge clk); @(negedge clk);
        pulse_ok = !done;
    endtask

    logic [15:0] rv;
    bit          ev, pok;
    int          lat;
    logic [19:0] cl;

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        chk(ctrl == 20'h0 && !done && !err, "R1 in reset", {done, err, ctrl}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl == 20'h0 && !done && !err, "R1 after reset", {done, err, ctrl}, 0);

        // directed: write then read back at address 0xFFFF, slow ack
        dly = 4;
        xfer(1'b1, 16'hFFFF, 16'hA5C3, rv, ev, lat, cl, pok);
        shadow[15] = 16'hA5C3;
        chk(!ev, "R4 write no error", ev, 0);
        chk(pok, "R7 done single pulse", 0, 0);
        xfer(1'b0, 16'hFFFF, 16'h0, rv, ev, lat, cl, pok);
        chk(!ev && rv == 16'hA5C3, "R3 read back", rv, 16'hA5C3);

        // constrained random mix
        for (int t = 0; t < 40; t++) begin
            bit          w = 1'($urandom_range(0, 1));
            logic [15:0] a = 16'($urandom);
            logic [15:0] d = 16'($urandom);
            dly = $urandom_range(0, 4);
            xfer(w, a, d, rv, ev, lat, cl, pok);
            chk(!ev, w ? "R4 random write ok" : "R3 random read ok", ev, 0);
            chk(pok, "R7 done pulse", 0, 0);
            if (w) shadow[a[3:0]] = d;
            else chk(rv == shadow[a[3:0]], "R3 random read data", rv, shadow[a[3:0]]);
        end

        // R8: request noise during a write is ignored
        dly = 3;
        exp_addr = 16'h0002; exp_wdata = 16'h1357;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h0002; wdata = 16'h1357;
        @(negedge clk);
        addr = 16'h0009; wdata = 16'hDEAD; we = 1'b0;
        repeat (6) @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin @(negedge clk); lat++; end
        chk(!err, "R8 first transaction ok", err, 0);
        repeat (6) begin
            @(negedge clk);
            chk(ctrl == 20'h0 && !done, "R8 no second transaction", ctrl, 0);
        end
        shadow[2] = 16'h1357;
        xfer(1'b0, 16'h0002, 16'h0, rv, ev, lat, cl, pok);
        chk(rv == 16'h1357, "R8 data of running write kept", rv, 16'h1357);
        xfer(1'b0, 16'h0009, 16'h0, rv, ev, lat, cl, pok);
        chk(rv == shadow[9], "R8 noise address untouched", rv, shadow[9]);

        // R5/R6: ack stuck low
        mode = 1;
        xfer(1'b1, 16'h0033, 16'h4444, rv, ev, lat, cl, pok);
        chk(ev, "R5 timeout err", ev, 1);
        chk(lat == POLL + 1, "R5 timeout latency", lat, POLL + 1);
        chk(cl == 20'h0, "R6 cleared before err", cl, 0);
        chk(pok, "R7 err pulse", 0, 0);

        // ack stuck high: address handshake never completes
        mode = 2;
        xfer(1'b0, 16'h0044, 16'h0, rv, ev, lat, cl, pok);
        chk(ev, "R5 stuck-high err", ev, 1);
        chk(cl == 20'h0, "R6 stuck-high cleared", cl, 0);
        chk(lat <= 3 * POLL, "R5 stuck-high bounded", lat, 3 * POLL);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule